// File: doc/BRIEF.md
# Standby STOP-Mode Clock Sequencer

This block decides when a small microcontroller may enter its deepest standby state, and when it leaves it. The CPU raises a stop request. The sequencer then gates the CPU clock and shuts down the high-speed oscillator. It watches the interrupt flag and mask vectors on an always-on clock, and a released interrupt wakes the core. On release the oscillator is switched back on first. The CPU clock returns only after a programmable settling interval has been counted.

Two cases need special handling. First, a request that arrives while an unmasked interrupt is already waiting does not stop the oscillator. The block parks the CPU in a halt state instead and still counts the full settling interval before it resumes. Second, the sequencer drives two clock enables outside the main path. The ring-oscillator enable honours a software stop only when a static option permits it. The subsystem-clock enable tracks its use input in every state, so peripherals clocked from it keep running through standby.

Top module: `stop_clk_ctrl`

## Requirements
- R1: The clock-source code `cpu_clk_sel` is encoded as 00 for the high-speed clock, 01 for the ring oscillator, 10 for the subsystem clock and 11 reserved. A stop request is accepted only with code 00 or 01. With 10 or 11 the block stays in RUN.
- R2: In STOP (`mode` = 01), both `hs_osc_en` and `cpu_clk_en` are low.
- R3: A source is a wake source when `irq_flag[i]`=1 and `irq_mask[i]`=0. In STOP, any wake source moves the block to WAIT_STAB (`mode` = 11) at the next clock edge, with `hs_osc_en` high. Flags whose mask bit is 1 leave the block in STOP.
- R4: An accepted stop request that finds a wake source already present enters HALT (`mode` = 10). In HALT, `cpu_clk_en` is low and `hs_osc_en` stays high.
- R5: HALT and WAIT_STAB each last exactly 2^min(BASE_EXP + STEP_EXP*code, MAX_EXP) cycles, after which the block returns to RUN. `code` is the value of `stab_sel` captured when the stop request was accepted. Later changes to `stab_sel` do not affect the interval.
- R6: `cpu_clk_en` is high only in RUN (`mode` = 00).
- R7: One cycle after its inputs, `ring_osc_en` is low exactly when `opt_ro_stoppable`=1 and `ro_sw_stop`=1. This holds in every mode.
- R8: `sub_osc_en` equals `sub_clk_use` delayed by one cycle, in every mode, including STOP.
- R9: While reset is high, the block is in RUN with `hs_osc_en`, `ring_osc_en`, `sub_osc_en` and `cpu_clk_en` all high, and the settling counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Stop request from the CPU |
| cpu_clk_sel | input | 2 | Current CPU clock source code |
| irq_flag | input | IRQ_W | Interrupt request flags |
| irq_mask | input | IRQ_W | Interrupt mask flags (1 = masked) |
| opt_ro_stoppable | input | 1 | Static option: ring oscillator may be stopped by software |
| ro_sw_stop | input | 1 | Software request to stop the ring oscillator |
| sub_clk_use | input | 1 | Subsystem clock in use |
| stab_sel | input | SEL_W | Settling-interval select code |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| ring_osc_en | output | 1 | Ring oscillator enable |
| sub_osc_en | output | 1 | Subsystem oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| mode | output | 2 | State: 00 RUN, 01 STOP, 10 HALT, 11 WAIT_STAB |

## Verification
The stop request and an unmasked interrupt can arrive in the same cycle. That case must end in HALT, not in STOP followed by an immediate wake. The bench provokes it by raising a single unmasked flag bit, with every other bit masked, together with the request. It then checks that the very next state is HALT with the oscillator still enabled. Both this path and the ordinary STOP-then-wake path are swept over every select code and both permitted clock sources. Each time, the length of the settling interval is measured against the power-of-two formula, after `stab_sel` has been disturbed mid-interval.

// File: rtl/stop_clk_pkg.sv
package stop_clk_pkg;

   typedef enum logic [1:0] {
      PM_RUN  = 2'b00,
      PM_STOP = 2'b01,
      PM_HALT = 2'b10,
      PM_STAB = 2'b11
   } pm_state_t;

   localparam logic [1:0] SRC_HS  = 2'b00;
   localparam logic [1:0] SRC_RO  = 2'b01;
   localparam logic [1:0] SRC_SUB = 2'b10;

   function automatic int stab_exp(input int code, input int base_e,
                                   input int step_e, input int max_e);
      int e;
      e = base_e + step_e * code;
      if (e > max_e) e = max_e;
      return e;
   endfunction

endpackage

// File: rtl/scc_wake_detect.sv
module scc_wake_detect #(
   parameter int IRQ_W = 16
) (
   input  logic [IRQ_W-1:0] irq_flag,
   input  logic [IRQ_W-1:0] irq_mask,
   output logic             wake
);

   logic [IRQ_W-1:0] hit;

   for (genvar i = 0; i < IRQ_W; i++) begin : g_src
      assign hit[i] = irq_flag[i] & ~irq_mask[i];
   end

   assign wake = |hit;

endmodule

// File: rtl/scc_stab_timer.sv
module scc_stab_timer
   import stop_clk_pkg::*;
#(
   parameter int SEL_W    = 3,
   parameter int BASE_EXP = 11,
   parameter int STEP_EXP = 2,
   parameter int MAX_EXP  = 17
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [SEL_W-1:0] sel_in,
   input  logic             count_en,
   output logic             done
);

   localparam int CNT_W = MAX_EXP;
   localparam int NCODE = 1 << SEL_W;

   logic [CNT_W-1:0] last_tab [NCODE];
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt_q;

   for (genvar c = 0; c < NCODE; c++) begin : g_code
      localparam int E = stab_exp(c, BASE_EXP, STEP_EXP, MAX_EXP);
      assign last_tab[c] = CNT_W'((64'd1 << E) - 64'd1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q <= '0;
      end else if (load) begin
         sel_q <= sel_in;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || !count_en) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = count_en && (cnt_q == last_tab[sel_q]);

endmodule

// File: rtl/scc_aux_osc.sv
module scc_aux_osc (
   input  logic clk,
   input  logic rst,
   input  logic opt_ro_stoppable,
   input  logic ro_sw_stop,
   input  logic sub_clk_use,
   output logic ring_osc_en,
   output logic sub_osc_en
);

   always_ff @(posedge clk) begin
      if (rst) begin
         ring_osc_en <= 1'b1;
         sub_osc_en  <= 1'b1;
      end else begin
         ring_osc_en <= ~(opt_ro_stoppable & ro_sw_stop);
         sub_osc_en  <= sub_clk_use;
      end
   end

endmodule

// File: rtl/scc_seq.sv
module scc_seq
   import stop_clk_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       stop_req,
   input  logic [1:0] cpu_clk_sel,
   input  logic       wake,
   input  logic       stab_done,
   output logic       accept,
   output logic       counting,
   output pm_state_t  state
);

   pm_state_t nxt;
   logic      src_ok;

   assign src_ok   = (cpu_clk_sel == SRC_HS) || (cpu_clk_sel == SRC_RO);
   assign accept   = (state == PM_RUN) && stop_req && src_ok;
   assign counting = (state == PM_HALT) || (state == PM_STAB);

   always_comb begin
      nxt = state;
      unique case (state)
         PM_RUN:  if (accept) nxt = wake ? PM_HALT : PM_STOP;
         PM_STOP: if (wake) nxt = PM_STAB;
         PM_HALT,
         PM_STAB: if (stab_done) nxt = PM_RUN;
         default: nxt = PM_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= PM_RUN;
      else     state <= nxt;
   end

endmodule

// File: rtl/stop_clk_ctrl.sv
module stop_clk_ctrl
   import stop_clk_pkg::*;
#(
   parameter int IRQ_W    = 16,
   parameter int SEL_W    = 3,
   parameter int BASE_EXP = 11,
   parameter int STEP_EXP = 2,
   parameter int MAX_EXP  = 17
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             stop_req,
   input  logic [1:0]       cpu_clk_sel,
   input  logic [IRQ_W-1:0] irq_flag,
   input  logic [IRQ_W-1:0] irq_mask,
   input  logic             opt_ro_stoppable,
   input  logic             ro_sw_stop,
   input  logic             sub_clk_use,
   input  logic [SEL_W-1:0] stab_sel,
   output logic             hs_osc_en,
   output logic             ring_osc_en,
   output logic             sub_osc_en,
   output logic             cpu_clk_en,
   output logic [1:0]       mode
);

   if (IRQ_W < 1) begin : g_bad_irq
      $error("IRQ_W must be at least 1");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("SEL_W must lie in 1..4");
   end
   if (BASE_EXP < 1 || STEP_EXP < 0) begin : g_bad_exp
      $error("BASE_EXP must be >= 1 and STEP_EXP >= 0");
   end
   if (MAX_EXP < BASE_EXP || MAX_EXP > 30) begin : g_bad_max
      $error("MAX_EXP must lie in BASE_EXP..30");
   end

   logic      wake;
   logic      accept;
   logic      counting;
   logic      stab_done;
   pm_state_t state;

   scc_wake_detect #(.IRQ_W(IRQ_W)) wake_i (
      .irq_flag (irq_flag),
      .irq_mask (irq_mask),
      .wake     (wake)
   );

   scc_seq seq_i (
      .clk         (clk),
      .rst         (rst),
      .stop_req    (stop_req),
      .cpu_clk_sel (cpu_clk_sel),
      .wake        (wake),
      .stab_done   (stab_done),
      .accept      (accept),
      .counting    (counting),
      .state       (state)
   );

   scc_stab_timer #(
      .SEL_W    (SEL_W),
      .BASE_EXP (BASE_EXP),
      .STEP_EXP (STEP_EXP),
      .MAX_EXP  (MAX_EXP)
   ) timer_i (
      .clk      (clk),
      .rst      (rst),
      .load     (accept),
      .sel_in   (stab_sel),
      .count_en (counting),
      .done     (stab_done)
   );

   scc_aux_osc aux_i (
      .clk              (clk),
      .rst              (rst),
      .opt_ro_stoppable (opt_ro_stoppable),
      .ro_sw_stop       (ro_sw_stop),
      .sub_clk_use      (sub_clk_use),
      .ring_osc_en      (ring_osc_en),
      .sub_osc_en       (sub_osc_en)
   );

   assign hs_osc_en  = (state != PM_STOP);
   assign cpu_clk_en = (state == PM_RUN);
   assign mode       = state;

endmodule

// File: rtl/stop_clk_ctrl_chk.sv
module stop_clk_ctrl_chk #(
   parameter int IRQ_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             stop_req,
   input logic [1:0]       cpu_clk_sel,
   input logic [IRQ_W-1:0] irq_flag,
   input logic [IRQ_W-1:0] irq_mask,
   input logic             opt_ro_stoppable,
   input logic             ro_sw_stop,
   input logic             sub_clk_use,
   input logic             hs_osc_en,
   input logic             ring_osc_en,
   input logic             sub_osc_en,
   input logic             cpu_clk_en,
   input logic [1:0]       mode
);

   logic pend;
   assign pend = |(irq_flag & ~irq_mask);

   // R1
   bad_src_stays_run_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'b00 && cpu_clk_sel[1]) |=> (mode == 2'b00));

   // R2
   stop_gates_clocks_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'b01) |-> (!hs_osc_en && !cpu_clk_en));

   // R3
   wake_leaves_stop_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'b01 && pend) |=> (mode == 2'b11 && hs_osc_en));

   // R3
   masked_keeps_stop_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'b01 && !pend) |=> (mode == 2'b01));

   // R4
   pending_goes_halt_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'b00 && stop_req && !cpu_clk_sel[1] && pend)
      |=> (mode == 2'b10 && hs_osc_en && !cpu_clk_en));

   // R6
   cpu_off_outside_run_chk: assert property (@(posedge clk) disable iff (rst)
      (mode != 2'b00) |-> !cpu_clk_en);

   // R7
   ring_enable_rule_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (ring_osc_en == !($past(opt_ro_stoppable) && $past(ro_sw_stop))));

   // R8
   sub_follows_use_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (sub_osc_en == $past(sub_clk_use)));

   // R9
   reset_state_chk: assert property (@(posedge clk)
      $past(rst) |-> (mode == 2'b00 || !rst));

endmodule

bind stop_clk_ctrl stop_clk_ctrl_chk #(.IRQ_W(IRQ_W)) chk_i (.*);

// File: tb/stop_clk_ctrl_tb_top.sv
module stop_clk_ctrl_tb_top;

   localparam int IRQ_W = 16;
   localparam int SEL_W = 3;
   localparam int BASE_E = 2;
   localparam int STEP_E = 1;
   localparam int MAX_E = 6;

   logic             clk = 1'b0;
   logic             rst;
   logic             stop_req;
   logic [1:0]       cpu_clk_sel;
   logic [IRQ_W-1:0] irq_flag;
   logic [IRQ_W-1:0] irq_mask;
   logic             opt_ro_stoppable;
   logic             ro_sw_stop;
   logic             sub_clk_use;
   logic [SEL_W-1:0] stab_sel;
   logic             hs_osc_en;
   logic             ring_osc_en;
   logic             sub_osc_en;
   logic             cpu_clk_en;
   logic [1:0]       mode;

   int checks = 0;
   int errors = 0;
   bit done_flag = 0;

   always #2.5 clk = ~clk;

   stop_clk_ctrl #(
      .IRQ_W(IRQ_W), .SEL_W(SEL_W),
      .BASE_EXP(BASE_E), .STEP_EXP(STEP_E), .MAX_EXP(MAX_E)
   ) dut_i (
      .clk(clk), .rst(rst), .stop_req(stop_req), .cpu_clk_sel(cpu_clk_sel),
      .irq_flag(irq_flag), .irq_mask(irq_mask),
      .opt_ro_stoppable(opt_ro_stoppable), .ro_sw_stop(ro_sw_stop),
      .sub_clk_use(sub_clk_use), .stab_sel(stab_sel),
      .hs_osc_en(hs_osc_en), .ring_osc_en(ring_osc_en),
      .sub_osc_en(sub_osc_en), .cpu_clk_en(cpu_clk_en), .mode(mode)
   );

   function automatic int exp_len(input int code);
      int e;
      e = BASE_E + STEP_E * code;
      if (e > MAX_E) e = MAX_E;
      return 1 << e;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // Counts the cycles spent in state st, starting at the current negedge.
   task automatic measure(input logic [1:0] st, output int w);
      w = 0;
      while (mode == st && w < 1000) begin
         w++;
         @(negedge clk);
      end
   endtask

   task automatic do_stop(input logic [1:0] sel, input int code, input int b);
      int w;
      @(negedge clk);
      cpu_clk_sel = sel; stab_sel = SEL_W'(code);
      irq_flag = '0; irq_mask = '0; stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0; stab_sel = ~SEL_W'(code);
      check("R2 stop mode", mode, 1);
      check("R2 hs off", hs_osc_en, 0);
      check("R6 cpu off in stop", cpu_clk_en, 0);
      repeat (3) @(negedge clk);
      check("R2 stop held", mode, 1);
      irq_flag[b] = 1'b1;
      @(negedge clk);
      check("R3 wake to stab", mode, 3);
      check("R3 hs on", hs_osc_en, 1);
      check("R6 cpu off in stab", cpu_clk_en, 0);
      measure(2'b11, w);
      check("R5 stab length", w, exp_len(code));
      check("R6 cpu on in run", cpu_clk_en, 1);
      check("R5 back to run", mode, 0);
      irq_flag = '0;
   endtask

   task automatic do_halt(input logic [1:0] sel, input int code, input int b);
      int w;
      @(negedge clk);
      cpu_clk_sel = sel; stab_sel = SEL_W'(code);
      irq_mask = ~(IRQ_W'(1) << b); irq_flag = '1; stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0; stab_sel = ~SEL_W'(code);
      check("R4 halt mode", mode, 2);
      check("R4 hs kept on", hs_osc_en, 1);
      check("R4 cpu off", cpu_clk_en, 0);
      measure(2'b10, w);
      check("R5 halt length", w, exp_len(code));
      check("R5 halt to run", mode, 0);
      irq_flag = '0; irq_mask = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      rst = 1'b1; stop_req = 1'b0; cpu_clk_sel = 2'b00;
      irq_flag = '0; irq_mask = '0; opt_ro_stoppable = 1'b0;
      ro_sw_stop = 1'b0; sub_clk_use = 1'b0; stab_sel = '0;
      repeat (3) @(negedge clk);
      // R9 reset values
      check("R9 mode", mode, 0);
      check("R9 hs", hs_osc_en, 1);
      check("R9 ring", ring_osc_en, 1);
      check("R9 sub", sub_osc_en, 1);
      check("R9 cpu", cpu_clk_en, 1);
      rst = 1'b0;
      @(negedge clk);
      check("R8 sub follows", sub_osc_en, 0);

      // R1 rejected sources
      for (int s = 2; s < 4; s++) begin
         @(negedge clk);
         cpu_clk_sel = 2'(s); stop_req = 1'b1;
         repeat (2) @(negedge clk);
         check("R1 ignored source", mode, 0);
         check("R1 cpu stays on", cpu_clk_en, 1);
         stop_req = 1'b0;
      end

      // R2 R3 R4 R5 sweep over sources and codes
      for (int s = 0; s < 2; s++) begin
         for (int c = 0; c < (1 << SEL_W); c++) begin
            do_stop(2'(s), c, (c * 5 + s) % IRQ_W);
            do_halt(2'(s), c, (c * 3 + s + 7) % IRQ_W);
         end
      end

      // R3 masked flags do not release
      @(negedge clk);
      cpu_clk_sel = 2'b01; stab_sel = 3'd0; stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      irq_mask = '1; irq_flag = '1;
      repeat (4) @(negedge clk);
      check("R3 masked stays stop", mode, 1);
      // R7 R8 sweep while in STOP
      for (int k = 0; k < 8; k++) begin
         opt_ro_stoppable = k[0]; ro_sw_stop = k[1]; sub_clk_use = k[2];
         @(negedge clk);
         check("R7 ring enable", ring_osc_en, (k[0] && k[1]) ? 0 : 1);
         check("R8 sub in stop", sub_osc_en, k[2]);
         check("R2 still stop", mode, 1);
      end
      irq_mask[9] = 1'b0;
      @(negedge clk);
      check("R3 unmask wakes", mode, 3);
      irq_flag = '0; irq_mask = '0;
      repeat (80) @(negedge clk);
      check("R5 run after wake", mode, 0);

      // R7 R8 sweep in RUN
      for (int k = 0; k < 8; k++) begin
         opt_ro_stoppable = k[2]; ro_sw_stop = k[0]; sub_clk_use = k[1];
         @(negedge clk);
         check("R7 ring in run", ring_osc_en, (k[2] && k[0]) ? 0 : 1);
         check("R8 sub in run", sub_osc_en, k[1]);
      end

      finish_run();
   end

endmodule